// File: doc/BRIEF.md
# Saturating Q15/Q31 Multiply-Accumulate Unit

This block performs fixed-point arithmetic on signed fractional data: 16-bit operands in Q15 and 32-bit accumulators in Q31. An opcode picks one operation per cycle. The operations are:

- a widening fractional multiply;
- multiply-accumulate and multiply-subtract, each with a rounded 16-bit variant;
- saturating 32-bit add and subtract;
- rounding of a 32-bit value to 16 bits;
- a 16-bit fractional multiply, with or without rounding.

Every clamp that occurs is reported on a saturation flag.

The inputs are `acc_i`, `a_i`, `b_i` and `op_i`. They are sampled on each rising clock edge, and the result is registered, so it appears one cycle later. A result that is 16 bits wide is returned sign-extended in `res_o`. The 32-bit add and subtract use `{a_i, b_i}` as their second operand, with `a_i` as the upper half. A dataflow controller issues one opcode per cycle and collects the registered result on the next cycle.

Top module: `fxp_mac_unit`

## Requirements
- R1: Opcode 0 (long multiply) returns twice the signed product of a_i and b_i as a 32-bit value. When both operands are 0x8000 the result is 0x7FFFFFFF and sat_o is 1.
- R2: Opcode 5 (long add) returns acc_i + {a_i,b_i}. On signed overflow the result clamps to 0x7FFFFFFF when the true sum is positive, or to 0x80000000 when it is negative, and sat_o is set.
- R3: Opcode 6 (long subtract) returns acc_i - {a_i,b_i}, clamped in the same way as R2.
- R4: Opcode 1 (multiply-accumulate) returns acc_i plus the R1 product, with saturation.
- R5: Opcode 2 (multiply-subtract) returns acc_i minus the R1 product, with saturation.
- R6: Opcodes 3 and 4 first form the R4 or R5 result respectively. They then add 0x8000 with 32-bit wraparound and return bits 31:16 of the sum, sign-extended. The rounding add never clamps and never sets sat_o.
- R7: Opcode 7 (round) adds 0x8000 to acc_i with saturation and returns bits 31:16 of the result, sign-extended.
- R8: Opcode 8 (short multiply) returns the signed product shifted arithmetically right by 15. The result is clamped to the range 0x8000 to 0x7FFF and sign-extended.
- R9: Opcode 9 (rounded short multiply) adds 0x4000 to the product before the R8 shift and clamp.
- R10: Opcodes 10 to 15 return 0, set illegal_o and clear sat_o.
- R11: sat_o is 1 exactly when a clamp happened in the operation that produced the current result. This includes the product clamp of R1 inside opcodes 1 to 4.
- R12: res_o, sat_o and illegal_o are 0 during reset. Each result appears on the first rising edge after its inputs are presented, and stays unchanged until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation code |
| acc_i | input | 32 | Q31 accumulator operand |
| a_i | input | 16 | Q15 operand A (upper half of the long operand) |
| b_i | input | 16 | Q15 operand B (lower half of the long operand) |
| res_o | output | 32 | Registered result; 16-bit results are sign-extended |
| sat_o | output | 1 | A clamp occurred in this result |
| illegal_o | output | 1 | The opcode was unused |

## Verification
The hardest conditions to reach are the clamps. Each one needs a precise operand pair: 0x8000 times 0x8000 for the product clamp, and an accumulator close to full scale for the add and subtract clamps. A third case is a multiply-accumulate that saturates but whose rounding add then wraps silently. Uniform random operands almost never produce these conditions. For that reason the random generator draws each operand from a set of extreme values a quarter of the time. Directed cases also place the accumulator at 0x7FFFFFFF, 0x80000000 and 0x7FFF8000.

// File: rtl/fxp_mac_pkg.sv
package fxp_mac_pkg;
  localparam int unsigned OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_MUL_L  = 4'd0,
    OP_MAC    = 4'd1,
    OP_MSU    = 4'd2,
    OP_MAC_R  = 4'd3,
    OP_MSU_R  = 4'd4,
    OP_ADD_L  = 4'd5,
    OP_SUB_L  = 4'd6,
    OP_RND    = 4'd7,
    OP_MUL_S  = 4'd8,
    OP_MUL_SR = 4'd9
  } fxp_op_e;
endpackage

// File: rtl/fxp_frac_mul.sv
module fxp_frac_mul #(
  parameter int unsigned DW = 16,
  localparam int unsigned AW = 2*DW
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [AW-1:0] prod_o,
  output logic [AW-1:0] dbl_o,
  output logic          clamp_o
);
  localparam logic [AW-1:0] P_OVF = AW'(1) << (AW-2);
  localparam logic [AW-1:0] MAX_L = {1'b0, {(AW-1){1'b1}}};

  logic signed [AW-1:0] p;
  assign p       = $signed({{DW{a_i[DW-1]}}, a_i}) * $signed({{DW{b_i[DW-1]}}, b_i});
  assign prod_o  = p;
  // only full-scale negative squared overflows when doubled
  assign clamp_o = (p == P_OVF);
  assign dbl_o   = clamp_o ? MAX_L : {p[AW-2:0], 1'b0};
endmodule

// File: rtl/fxp_sat_addsub.sv
module fxp_sat_addsub #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         ovf_o
);
  localparam logic [W-1:0] MAX_V = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MIN_V = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] yy, raw;
  logic         same_in;

  assign yy      = sub_i ? ~y_i : y_i;
  assign raw     = x_i + yy + {{(W-1){1'b0}}, sub_i};
  assign same_in = (x_i[W-1] == y_i[W-1]);
  assign ovf_o   = (sub_i ? !same_in : same_in) && (raw[W-1] != x_i[W-1]);
  assign sum_o   = ovf_o ? (x_i[W-1] ? MIN_V : MAX_V) : raw;
endmodule

// File: rtl/fxp_sat_narrow.sv
module fxp_sat_narrow #(
  parameter int unsigned IW = 32,
  parameter int unsigned OW = 16
) (
  input  logic [IW-1:0] in_i,
  output logic [OW-1:0] out_o,
  output logic          clamp_o
);
  localparam logic [OW-1:0] MAX_S = {1'b0, {(OW-1){1'b1}}};
  localparam logic [OW-1:0] MIN_S = {1'b1, {(OW-1){1'b0}}};

  logic [IW-OW:0] hi;
  assign hi      = in_i[IW-1:OW-1];
  assign clamp_o = !((&hi) || (~|hi));
  assign out_o   = clamp_o ? (in_i[IW-1] ? MIN_S : MAX_S) : in_i[OW-1:0];
endmodule

// File: rtl/fxp_mac_unit.sv
module fxp_mac_unit
  import fxp_mac_pkg::*;
#(
  parameter int unsigned DW = 16,
  localparam int unsigned AW = 2*DW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [OP_W-1:0] op_i,
  input  logic [AW-1:0]   acc_i,
  input  logic [DW-1:0]   a_i,
  input  logic [DW-1:0]   b_i,
  output logic [AW-1:0]   res_o,
  output logic            sat_o,
  output logic            illegal_o
);
  localparam logic [AW-1:0] RND_L = AW'(1) << DW;
  localparam logic [AW-1:0] HALF_L = AW'(1) << (DW-1);
  localparam logic [AW-1:0] HALF_S = AW'(1) << (DW-2);

  fxp_op_e op;
  assign op = fxp_op_e'(op_i);

  logic [AW-1:0] prod, dbl;
  logic          p_clamp;

  fxp_frac_mul #(.DW(DW)) u_mul (
    .a_i(a_i), .b_i(b_i), .prod_o(prod), .dbl_o(dbl), .clamp_o(p_clamp)
  );

  logic [AW-1:0] add_y, sum;
  logic          add_sub, ovf;

  always_comb begin
    add_y   = '0;
    add_sub = 1'b0;
    unique case (op)
      OP_MAC, OP_MAC_R: add_y = dbl;
      OP_MSU, OP_MSU_R: begin add_y = dbl; add_sub = 1'b1; end
      OP_ADD_L:         add_y = {a_i, b_i};
      OP_SUB_L:         begin add_y = {a_i, b_i}; add_sub = 1'b1; end
      OP_RND:           add_y = HALF_L;
      default:          ;
    endcase
  end

  fxp_sat_addsub #(.W(AW)) u_add (
    .x_i(acc_i), .y_i(add_y), .sub_i(add_sub), .sum_o(sum), .ovf_o(ovf)
  );

  // wrapping round for the rounded MAC/MSU variants
  logic [AW-1:0] wrapped;
  assign wrapped = sum + HALF_L;

  // short multiply: variant 0 truncates, variant 1 rounds
  logic [DW-1:0] short_q [2];
  logic [1:0]    short_clamp;

  for (genvar k = 0; k < 2; k++) begin : g_mul16
    localparam logic [AW-1:0] BIAS = (k == 1) ? HALF_S : '0;
    logic [AW-1:0] biased, shifted;
    assign biased  = prod + BIAS;
    assign shifted = AW'($signed(biased) >>> (DW-1));
    fxp_sat_narrow #(.IW(AW), .OW(DW)) u_nar (
      .in_i(shifted), .out_o(short_q[k]), .clamp_o(short_clamp[k])
    );
  end

  logic [AW-1:0] res_d;
  logic          sat_d, ill_d;

  always_comb begin
    res_d = '0;
    sat_d = 1'b0;
    ill_d = 1'b0;
    unique case (op)
      OP_MUL_L: begin res_d = dbl; sat_d = p_clamp; end
      OP_MAC, OP_MSU: begin res_d = sum; sat_d = ovf | p_clamp; end
      OP_ADD_L, OP_SUB_L: begin res_d = sum; sat_d = ovf; end
      OP_MAC_R, OP_MSU_R: begin
        res_d = {{DW{wrapped[AW-1]}}, wrapped[AW-1:DW]};
        sat_d = ovf | p_clamp;
      end
      OP_RND: begin
        res_d = {{DW{sum[AW-1]}}, sum[AW-1:DW]};
        sat_d = ovf;
      end
      OP_MUL_S: begin
        res_d = {{DW{short_q[0][DW-1]}}, short_q[0]};
        sat_d = short_clamp[0];
      end
      OP_MUL_SR: begin
        res_d = {{DW{short_q[1][DW-1]}}, short_q[1]};
        sat_d = short_clamp[1];
      end
      default: ill_d = 1'b1;
    endcase
  end

  logic unused_rnd;
  assign unused_rnd = ^RND_L;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o     <= '0;
      sat_o     <= 1'b0;
      illegal_o <= 1'b0;
    end else begin
      res_o     <= res_d;
      sat_o     <= sat_d;
      illegal_o <= ill_d;
    end
  end
endmodule

// File: rtl/fxp_mac_unit_chk.sv
module fxp_mac_unit_chk
  import fxp_mac_pkg::*;
#(
  parameter int unsigned DW = 16,
  localparam int unsigned AW = 2*DW
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [OP_W-1:0] op_i,
  input logic [DW-1:0]   a_i,
  input logic [DW-1:0]   b_i,
  input logic [AW-1:0]   res_o,
  input logic            sat_o,
  input logic            illegal_o
);
  localparam logic [AW-1:0] MAX_L = {1'b0, {(AW-1){1'b1}}};
  localparam logic [AW-1:0] MIN_L = {1'b1, {(AW-1){1'b0}}};
  localparam logic [DW-1:0] NEG1  = {1'b1, {(DW-1){1'b0}}};

  assert_illegal_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (res_o == '0 && !sat_o));

  assert_illegal_flag_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i > 4'd9) |=> illegal_o);

  assert_mul_clamp_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_MUL_L && a_i == NEG1 && b_i == NEG1) |=> (res_o == MAX_L && sat_o));

  assert_short_ext_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_MUL_S || op_i == OP_MUL_SR) |=>
      (res_o[AW-1:DW-1] == '0 || res_o[AW-1:DW-1] == '1));

  assert_add_clamp_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_ADD_L || op_i == OP_SUB_L) |=>
      (!sat_o || res_o == MAX_L || res_o == MIN_L));
endmodule

bind fxp_mac_unit fxp_mac_unit_chk #(.DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .a_i(a_i), .b_i(b_i),
  .res_o(res_o), .sat_o(sat_o), .illegal_o(illegal_o)
);

// File: tb/fxp_mac_unit_tb.sv
module fxp_mac_unit_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  op_i = '0;
  logic [31:0] acc_i = '0;
  logic [15:0] a_i = '0, b_i = '0;
  logic [31:0] res_o;
  logic        sat_o, illegal_o;

  int n_run = 0, n_fail = 0;
  logic [31:0] last_res = '0;

  always #10 clk_i = ~clk_i;

  fxp_mac_unit u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .acc_i(acc_i),
    .a_i(a_i), .b_i(b_i), .res_o(res_o), .sat_o(sat_o), .illegal_o(illegal_o)
  );

  function automatic longint clip32(input longint v, inout logic s);
    if (v > 64'sh7FFFFFFF) begin s = 1'b1; return 64'sh7FFFFFFF; end
    if (v < -64'sh80000000) begin s = 1'b1; return -64'sh80000000; end
    return v;
  endfunction

  function automatic longint clip16(input longint v, inout logic s);
    if (v > 32767) begin s = 1'b1; return 32767; end
    if (v < -32768) begin s = 1'b1; return -32768; end
    return v;
  endfunction

  function automatic void ref_model(input logic [3:0] op, input logic [31:0] acc,
      input logic [15:0] a, input logic [15:0] b,
      output logic [31:0] r, output logic s, output logic il);
    longint p, lm, t, sacc, lop;
    logic ps;
    logic [31:0] u;
    p    = longint'($signed(a)) * longint'($signed(b));
    ps   = (p == 64'sh40000000);
    lm   = ps ? 64'sh7FFFFFFF : 2 * p;
    sacc = longint'($signed(acc));
    lop  = longint'($signed({a, b}));
    r = '0; s = 1'b0; il = 1'b0;
    case (op)
      4'd0: begin r = lm[31:0]; s = ps; end
      4'd1: begin t = clip32(sacc + lm, s); s |= ps; r = t[31:0]; end
      4'd2: begin t = clip32(sacc - lm, s); s |= ps; r = t[31:0]; end
      4'd3, 4'd4: begin
        t = clip32((op == 4'd3) ? sacc + lm : sacc - lm, s); s |= ps;
        u = t[31:0] + 32'h8000;
        r = {{16{u[31]}}, u[31:16]};
      end
      4'd5: begin t = clip32(sacc + lop, s); r = t[31:0]; end
      4'd6: begin t = clip32(sacc - lop, s); r = t[31:0]; end
      4'd7: begin t = clip32(sacc + 32768, s); r = {{16{t[31]}}, t[31:16]}; end
      4'd8: begin t = clip16(p >>> 15, s); r = {{16{t[15]}}, t[15:0]}; end
      4'd9: begin t = clip16((p + 16384) >>> 15, s); r = {{16{t[15]}}, t[15:0]}; end
      default: il = 1'b1;
    endcase
  endfunction

  function automatic string op_tag(input logic [3:0] op);
    case (op)
      4'd0: return "R1";
      4'd1: return "R4";
      4'd2: return "R5";
      4'd3, 4'd4: return "R6";
      4'd5: return "R2";
      4'd6: return "R3";
      4'd7: return "R7";
      4'd8: return "R8";
      4'd9: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic run_op(input logic [3:0] op, input logic [31:0] acc,
      input logic [15:0] a, input logic [15:0] b, input string tag);
    logic [31:0] er; logic es, ei;
    ref_model(op, acc, a, b, er, es, ei);
    @(negedge clk_i);
    op_i = op; acc_i = acc; a_i = b === 'x ? '0 : a; b_i = b;
    #1;
    n_run++;
    if (res_o !== last_res) begin
      n_fail++;
      $display("FAIL R12 output moved before edge: act=%h exp=%h", res_o, last_res);
    end
    @(negedge clk_i);
    n_run++;
    if (res_o !== er || sat_o !== es || illegal_o !== ei) begin
      n_fail++;
      $display("FAIL %s R11 op=%0d acc=%h a=%h b=%h act=%h/%b/%b exp=%h/%b/%b",
               tag, op, acc, a, b, res_o, sat_o, illegal_o, er, es, ei);
    end
    last_res = er;
  endtask

  function automatic logic [15:0] pick16();
    case ($urandom % 8)
      0: return 16'h8000;
      1: return 16'h7FFF;
      default: return 16'($urandom);
    endcase
  endfunction

  function automatic logic [31:0] pick32();
    case ($urandom % 8)
      0: return 32'h7FFFFFFF;
      1: return 32'h80000000;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    n_run++;
    if (res_o !== '0 || sat_o !== 1'b0 || illegal_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R12 reset state act=%h/%b/%b exp=0/0/0", res_o, sat_o, illegal_o);
    end
    rst_ni = 1'b1;

    run_op(4'd0, 32'h0, 16'h8000, 16'h8000, "R1 clamp");
    run_op(4'd0, 32'h0, 16'h4000, 16'hC000, "R1");
    run_op(4'd5, 32'h7FFFFFFF, 16'h0000, 16'h0001, "R2 pos ovf");
    run_op(4'd5, 32'h80000000, 16'hFFFF, 16'hFFFF, "R2 neg ovf");
    run_op(4'd6, 32'h80000000, 16'h0000, 16'h0001, "R3 neg ovf");
    run_op(4'd6, 32'h7FFFFFFF, 16'hFFFF, 16'hFFFF, "R3 pos ovf");
    run_op(4'd1, 32'h7FFFFFFF, 16'h0001, 16'h0001, "R4 sat");
    run_op(4'd1, 32'h00000000, 16'h8000, 16'h8000, "R4 R11 product clamp");
    run_op(4'd2, 32'h80000000, 16'h0001, 16'h0001, "R5 sat");
    run_op(4'd3, 32'h7FFFFFFF, 16'h0000, 16'h0000, "R6 wrap");
    run_op(4'd3, 32'h7FFFFFFF, 16'h7FFF, 16'h7FFF, "R6 sat then wrap");
    run_op(4'd4, 32'h00018000, 16'h0000, 16'h0000, "R6 msu");
    run_op(4'd7, 32'h7FFF8000, 16'h0, 16'h0, "R7 sat");
    run_op(4'd7, 32'h12347FFF, 16'h0, 16'h0, "R7");
    run_op(4'd8, 32'h0, 16'h8000, 16'h8000, "R8 clamp");
    run_op(4'd8, 32'h0, 16'hFFFF, 16'h0001, "R8 floor");
    run_op(4'd9, 32'h0, 16'h0001, 16'h4000, "R9 round up");
    run_op(4'd9, 32'h0, 16'h8000, 16'h8000, "R9 clamp");
    run_op(4'd12, 32'hDEADBEEF, 16'h8000, 16'h8000, "R10");
    run_op(4'd15, 32'h7FFFFFFF, 16'hFFFF, 16'hFFFF, "R10");

    for (int i = 0; i < 600; i++) begin
      logic [3:0] op;
      op = 4'($urandom % 16);
      run_op(op, pick32(), pick16(), pick16(), op_tag(op));
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule